// File: doc/BRIEF.md
# Clock Source Switch Controller with Oscillator-Loss Fallback

This block decides whether the system runs from an always-on internal RC clock or from an external oscillator. It is clocked by the RC clock. Software programs it through an 8-bit configuration word. Setting the request bit starts a settling wait, and the system keeps running from the RC clock while that wait lasts. When the wait ends, a registered select output moves a glitch-free clock mux over to the external source, and a read-only status bit reports the change.

When the fallback guard is enabled, a watchdog clocked from the RC clock checks that the external oscillator keeps toggling. If the oscillator falls silent, the block returns the system to the RC clock and raises a switch-event flag. It raises the same flag if the oscillator is already dead at the moment the settling wait ends. The flag drives an interrupt output through a separate enable.

Configuration word layout: bit 0 `req` (request external source; reads 1 while waiting or running external), bit 1 `guard_en` (fallback guard), bit 2 `irq_en`, bit 3 `evt` (switch-event flag; writing 0 clears it, writing 1 leaves it unchanged), bit 4 `on_ext` (read-only status), bits 7:5 `settle` (settling code S, with base period Nb = 2^(S+4) RC cycles).

Top module: `clksw_ctrl`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x00, `clk_sel_ext` is 0 and `irq_o` is 0.
- R2: A write with bit 0 = 1 while the block is on the RC clock starts a settling wait. During the wait, `clk_sel_ext` and status bit 4 stay 0 and bit 0 reads 1.
- R3: `clk_sel_ext` rises no sooner than Nb+1 and no later than 2·Nb RC cycles after the clock edge that accepts the request write, where Nb = 2^(S+4).
- R4: When the wait completes with the oscillator alive, `clk_sel_ext` becomes 1 and status bit 4 reads 1.
- R5: With bit 1 = 0, a silent external oscillator never changes the source and never sets the flag.
- R6: With bit 1 = 1 and the block on the external source, the source returns to RC once the oscillator has not toggled for 8 RC cycles (counted after a 2-flop synchronizer). At that point bits 4 and 0 clear and bit 3 sets. The switch never happens fewer than 5 cycles after the oscillator stops.
- R7: If the guard reports the oscillator halted when the settling wait ends, the block stays on RC, sets bit 3 and clears bit 0.
- R8: Writing 0 to bit 3 clears the flag, and writing 1 leaves it unchanged. A flag-setting event in the same cycle as a clearing write wins.
- R9: `irq_o` is 1 exactly when both the flag and bit 2 are 1. The flag sets whatever bit 2 holds.
- R10: A write with bit 0 = 0 during a wait or while on the external source returns the block to RC at the next edge.
- R11: `clk_sel_ext` is a register and rises only at the end of a settling wait, never in the cycle that accepts the request write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rc_clk | input | 1 | Always-running internal RC clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | Raw external oscillator clock |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration and status readback |
| clk_sel_ext | output | 1 | Registered mux select, 1 = external source |
| irq_o | output | 1 | Switch-event interrupt request |

## Verification
A configuration write takes effect at the clock edge that samples it. The bench drives inputs and samples outputs on falling edges, so every register result is checked half a cycle after that edge. The settling wait starts on an unknown phase of a free-running base counter. The bench therefore counts the edges from the accepting edge to the rise of the select and checks that count against the window Nb+1 to 2·Nb. The oscillator watchdog adds synchronizer delay to an unknown toggle phase. For that reason the bench checks a point that must still show the external source (5 cycles after the stop) and a point by which the fallback must have happened (20 cycles after the stop).

// File: rtl/clksw_pkg.sv
package clksw_pkg;

  localparam int CFG_W      = 8;
  localparam int CODE_W     = 3;
  localparam int BASE_SHIFT = 4;
  localparam int QUIET_CYC  = 8;
  localparam int SYNC_DEPTH = 2;

  localparam int B_REQ      = 0;
  localparam int B_GUARD    = 1;
  localparam int B_IRQEN    = 2;
  localparam int B_EVT      = 3;
  localparam int B_ONEXT    = 4;
  localparam int B_CODE_LO  = 5;

  typedef enum logic [1:0] {
    SRC_RC   = 2'd0,
    SRC_WAIT = 2'd1,
    SRC_EXT  = 2'd2
  } src_state_e;

endpackage

// File: rtl/clksw_rst_sync.sv
module clksw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/clksw_halt_det.sv
module clksw_halt_det #(
  parameter int QUIET  = 8,
  parameter int STAGES = 2
) (
  input  logic rc_clk,
  input  logic rst_n,
  input  logic ext_clk,
  input  logic en,
  output logic halted
);

  localparam int CNT_W = $clog2(QUIET + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(QUIET);

  // Toggle flop in the external clock domain
  logic ext_tgl_q;
  always_ff @(posedge ext_clk or negedge rst_n) begin
    if (!rst_n) ext_tgl_q <= 1'b0;
    else        ext_tgl_q <= ~ext_tgl_q;
  end

  // Synchronizer plus one history stage for edge detection
  logic [STAGES:0] sync_q;
  logic [STAGES:0] sync_d;
  always_comb begin
    sync_d = {sync_q[STAGES-1:0], ext_tgl_q};
  end
  always_ff @(posedge rc_clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  logic seen_edge;
  assign seen_edge = sync_q[STAGES-1] ^ sync_q[STAGES];

  logic [CNT_W-1:0] quiet_q;
  logic [CNT_W-1:0] quiet_d;
  logic             quiet_ce;

  always_comb begin
    quiet_ce = 1'b0;
    quiet_d  = quiet_q;
    if (!en || seen_edge) begin
      quiet_ce = (quiet_q != '0);
      quiet_d  = '0;
    end else if (quiet_q != CNT_MAX) begin
      quiet_ce = 1'b1;
      quiet_d  = quiet_q + 1'b1;
    end
  end

  always_ff @(posedge rc_clk or negedge rst_n) begin
    if (!rst_n)        quiet_q <= '0;
    else if (quiet_ce) quiet_q <= quiet_d;
  end

  assign halted = en && (quiet_q == CNT_MAX);

  // R6: a halt is only declared after the synchronized toggle held still
  p_quiet_before_halt_r6: assert property (@(posedge rc_clk) disable iff (!rst_n)
    $rose(halted) |-> (sync_q[STAGES-1] == $past(sync_q[STAGES-1])));

endmodule

// File: rtl/clksw_settle_timer.sv
module clksw_settle_timer #(
  parameter int CODE_W = 3,
  parameter int SHIFT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cancel,
  input  logic [CODE_W-1:0] code,
  output logic              done
);

  localparam int BASE_W = (1 << CODE_W) - 1 + SHIFT;
  localparam int ELAP_W = BASE_W + 2;

  // Free-running base counter: the wait starts on an arbitrary phase of it
  logic [BASE_W-1:0] base_q;
  logic [BASE_W-1:0] base_d;
  logic [BASE_W-1:0] span_mask;
  logic              tick;

  always_comb begin
    base_d    = base_q + 1'b1;
    span_mask = (BASE_W'(1) << (int'(code) + SHIFT)) - 1'b1;
    tick      = &(base_q | ~span_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end

  logic busy_q, busy_d;
  logic armed_q, armed_d;
  logic ctl_ce;

  always_comb begin
    done    = busy_q && armed_q && tick;
    busy_d  = busy_q;
    armed_d = armed_q;
    if (start) begin
      busy_d  = 1'b1;
      armed_d = 1'b0;
    end else if (cancel || done) begin
      busy_d  = 1'b0;
      armed_d = 1'b0;
    end else if (busy_q && tick) begin
      armed_d = 1'b1;
    end
    ctl_ce = start || cancel || busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (ctl_ce) begin
      busy_q  <= busy_d;
      armed_q <= armed_d;
    end
  end

  // Elapsed-cycle counter for the window check
  logic [ELAP_W-1:0] elap_q;
  logic [ELAP_W-1:0] nbase;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      elap_q <= '0;
    else if (start)  elap_q <= '0;
    else if (busy_q) elap_q <= elap_q + 1'b1;
  end
  assign nbase = ELAP_W'(1) << (int'(code) + SHIFT);

  // R3: completion lies between Nb+1 and 2*Nb edges after the start edge
  p_wait_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (elap_q >= nbase && elap_q <= (nbase << 1) - 1'b1));

endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter int SETTLE_CODE_W = CODE_W,
  parameter int SETTLE_SHIFT  = BASE_SHIFT,
  parameter int QUIET_LIMIT   = QUIET_CYC,
  parameter int SYNC_STAGES   = SYNC_DEPTH
) (
  input  logic             rc_clk,
  input  logic             rst_n,
  input  logic             ext_clk,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             clk_sel_ext,
  output logic             irq_o
);

  logic rst_q_n;

  clksw_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (rc_clk),
    .arst_n (rst_n),
    .srst_n (rst_q_n)
  );

  src_state_e st_q, st_d;
  logic guard_q, guard_d;
  logic ien_q, ien_d;
  logic evt_q, evt_d;
  logic sel_q, sel_d;
  logic [SETTLE_CODE_W-1:0] code_q, code_d;

  logic wr_req, wr_drop, wr_clr;
  logic halted, settle_done, tmr_start, tmr_cancel;
  logic ev_fail, ev_dead, ev_any;
  logic ro_bit_unused;

  assign wr_req        = cfg_wr &&  cfg_wdata[B_REQ];
  assign wr_drop       = cfg_wr && !cfg_wdata[B_REQ];
  assign wr_clr        = cfg_wr && !cfg_wdata[B_EVT];
  assign ro_bit_unused = cfg_wdata[B_ONEXT];

  clksw_halt_det #(.QUIET(QUIET_LIMIT), .STAGES(SYNC_STAGES)) u_halt_det (
    .rc_clk  (rc_clk),
    .rst_n   (rst_q_n),
    .ext_clk (ext_clk),
    .en      (guard_q),
    .halted  (halted)
  );

  clksw_settle_timer #(.CODE_W(SETTLE_CODE_W), .SHIFT(SETTLE_SHIFT)) u_settle (
    .clk    (rc_clk),
    .rst_n  (rst_q_n),
    .start  (tmr_start),
    .cancel (tmr_cancel),
    .code   (code_q),
    .done   (settle_done)
  );

  // Source state next-state logic
  always_comb begin
    st_d    = st_q;
    ev_fail = 1'b0;
    ev_dead = 1'b0;
    unique case (st_q)
      SRC_RC: begin
        if (wr_req) st_d = SRC_WAIT;
      end
      SRC_WAIT: begin
        if (wr_drop) begin
          st_d = SRC_RC;
        end else if (settle_done) begin
          if (halted) begin
            st_d    = SRC_RC;
            ev_dead = 1'b1;
          end else begin
            st_d = SRC_EXT;
          end
        end
      end
      SRC_EXT: begin
        if (wr_drop) begin
          st_d = SRC_RC;
        end else if (halted) begin
          st_d    = SRC_RC;
          ev_fail = 1'b1;
        end
      end
      default: st_d = SRC_RC;
    endcase
    tmr_start  = (st_q == SRC_RC) && wr_req;
    tmr_cancel = (st_d == SRC_RC);
  end

  // Configuration and event flag next-state logic
  always_comb begin
    ev_any  = ev_fail || ev_dead;
    guard_d = cfg_wr ? cfg_wdata[B_GUARD] : guard_q;
    ien_d   = cfg_wr ? cfg_wdata[B_IRQEN] : ien_q;
    code_d  = cfg_wr ? cfg_wdata[B_CODE_LO +: SETTLE_CODE_W] : code_q;
    if (ev_any)      evt_d = 1'b1;
    else if (wr_clr) evt_d = 1'b0;
    else             evt_d = evt_q;
    sel_d = (st_d == SRC_EXT);
  end

  always_ff @(posedge rc_clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      st_q    <= SRC_RC;
      sel_q   <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      sel_q   <= sel_d;
      evt_q   <= evt_d;
    end
  end

  always_ff @(posedge rc_clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      guard_q <= 1'b0;
      ien_q   <= 1'b0;
      code_q  <= '0;
    end else if (cfg_wr) begin
      guard_q <= guard_d;
      ien_q   <= ien_d;
      code_q  <= code_d;
    end
  end

  always_comb begin
    cfg_rdata                                  = '0;
    cfg_rdata[B_REQ]                           = (st_q != SRC_RC);
    cfg_rdata[B_GUARD]                         = guard_q;
    cfg_rdata[B_IRQEN]                         = ien_q;
    cfg_rdata[B_EVT]                           = evt_q;
    cfg_rdata[B_ONEXT]                         = sel_q;
    cfg_rdata[B_CODE_LO +: SETTLE_CODE_W]      = code_q;
  end

  assign clk_sel_ext = sel_q;
  assign irq_o       = evt_q && ien_q;

  // R11: the select only rises out of a settling wait
  p_rise_from_wait_r11: assert property (@(posedge rc_clk) disable iff (!rst_q_n)
    $rose(clk_sel_ext) |-> ($past(st_q) == SRC_WAIT));

  // R6: a halt while external forces RC and sets the flag
  p_fallback_r6: assert property (@(posedge rc_clk) disable iff (!rst_q_n)
    (clk_sel_ext && halted && !wr_drop) |=> (!clk_sel_ext && evt_q));

  // R7: a dead oscillator at settle end keeps RC and flags it
  p_dead_osc_r7: assert property (@(posedge rc_clk) disable iff (!rst_q_n)
    ((st_q == SRC_WAIT) && settle_done && halted && !wr_drop) |=> (!clk_sel_ext && evt_q));

  // R5: with the guard off, the external source is kept
  p_guard_off_r5: assert property (@(posedge rc_clk) disable iff (!rst_q_n)
    (clk_sel_ext && !guard_q && !wr_drop) |=> clk_sel_ext);

  // R8: an event beats a clearing write in the same cycle
  p_set_wins_r8: assert property (@(posedge rc_clk) disable iff (!rst_q_n)
    (ev_any && wr_clr) |=> evt_q);

  // R8: a clearing write with no event clears the flag
  p_clear_r8: assert property (@(posedge rc_clk) disable iff (!rst_q_n)
    (wr_clr && !ev_any) |=> !evt_q);

  // R10: dropping the request returns to RC at once
  p_drop_r10: assert property (@(posedge rc_clk) disable iff (!rst_q_n)
    wr_drop |=> (!clk_sel_ext && !cfg_rdata[B_REQ]));

endmodule

// File: tb/clksw_ctrl_bench.sv
module clksw_ctrl_bench;

  logic       rc_clk = 1'b0;
  logic       rst_n  = 1'b0;
  logic       ext_clk = 1'b0;
  logic       ext_run = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       clk_sel_ext;
  logic       irq_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 rc_clk = ~rc_clk;

  initial begin
    forever begin
      #5;
      if (ext_run) ext_clk = ~ext_clk;
    end
  end

  clksw_ctrl u_clksw_ctrl (
    .rc_clk      (rc_clk),
    .rst_n       (rst_n),
    .ext_clk     (ext_clk),
    .cfg_wr      (cfg_wr),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .clk_sel_ext (clk_sel_ext),
    .irq_o       (irq_o)
  );

  function automatic logic [7:0] word(input logic req, input logic grd, input logic ien,
                                      input logic keep, input logic [2:0] code);
    return {code, 1'b0, keep, ien, grd, req};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge rc_clk);
    cfg_wr    = 1'b1;
    cfg_wdata = v;
    @(negedge rc_clk);
    cfg_wr    = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge rc_clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    check("R1 rdata", cfg_rdata, 8'h00);
    check("R1 clk_sel", clk_sel_ext, 0);
    check("R1 irq", irq_o, 0);
  endtask

  task automatic t_settle(input logic [2:0] code, input logic grd);
    int nb, c;
    nb = 1 << (code + 4);
    wr(word(1, grd, 0, 1, code));
    check("R11 no select on write edge", clk_sel_ext, 0);
    check("R2 req reads 1", cfg_rdata[0], 1);
    c = 0;
    while (!clk_sel_ext && c < 4 * nb) begin
      if (c == nb / 2) check("R2 still on RC mid-wait", cfg_rdata[4], 0);
      @(negedge rc_clk);
      c++;
    end
    check_rng("R3 settle window", c, nb + 1, 2 * nb);
    check("R4 status bit", cfg_rdata[4], 1);
    check("R4 select", clk_sel_ext, 1);
  endtask

  task automatic t_guard_off;
    ext_run = 1'b0;
    idle(30);
    check("R5 stays external", clk_sel_ext, 1);
    check("R5 flag untouched", cfg_rdata[3], 0);
    ext_run = 1'b1;
    idle(6);
  endtask

  task automatic t_fallback;
    wr(word(1, 1, 0, 1, 3'd0));
    idle(10);
    check("R6 running external", clk_sel_ext, 1);
    ext_run = 1'b0;
    idle(5);
    check("R6 not yet fallen back", clk_sel_ext, 1);
    idle(15);
    check("R6 back on RC", clk_sel_ext, 0);
    check("R6 status clear", cfg_rdata[4], 0);
    check("R6 req clear", cfg_rdata[0], 0);
    check("R6 flag set", cfg_rdata[3], 1);
    check("R9 irq gated off", irq_o, 0);
  endtask

  task automatic t_flag_irq;
    wr(word(0, 1, 1, 1, 3'd0));
    check("R9 irq when enabled", irq_o, 1);
    check("R8 write 1 keeps flag", cfg_rdata[3], 1);
    wr(word(0, 1, 1, 0, 3'd0));
    check("R8 flag cleared", cfg_rdata[3], 0);
    check("R9 irq low after clear", irq_o, 0);
    wr(word(0, 1, 0, 1, 3'd0));
    check("R8 write 1 does not set", cfg_rdata[3], 0);
  endtask

  task automatic t_dead_osc;
    idle(20);
    wr(word(1, 1, 0, 1, 3'd0));
    idle(40);
    check("R7 stays on RC", clk_sel_ext, 0);
    check("R7 flag set", cfg_rdata[3], 1);
    check("R7 req cleared", cfg_rdata[0], 0);
    wr(word(0, 1, 0, 0, 3'd0));
    ext_run = 1'b1;
    idle(6);
  endtask

  task automatic t_drop;
    wr(word(0, 0, 0, 1, 3'd2));
    check("R10 drop from external", clk_sel_ext, 0);
    check("R10 req reads 0", cfg_rdata[0], 0);
    wr(word(1, 0, 0, 1, 3'd0));
    idle(3);
    wr(word(0, 0, 0, 1, 3'd0));
    check("R10 drop during wait", cfg_rdata[0], 0);
    idle(40);
    check("R10 no late switch", clk_sel_ext, 0);
  endtask

  initial begin
    t_reset();
    t_settle(3'd0, 1'b0);
    t_guard_off();
    t_fallback();
    t_flag_irq();
    t_dead_osc();
    t_settle(3'd2, 1'b1);
    t_drop();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule